// File: doc/BRIEF.md
# Floppy Controller Command-Phase Sequencer

This block is the device-facing half of a floppy-controller register interface. The host pushes an opcode byte and its parameter bytes one at a time through a single data port. The sequencer decodes the opcode from the first byte and knows how many parameter bytes must follow. Once the last one arrives, it either returns straight to idle or turns the data port around so the host can read a fixed number of result bytes. After the final result byte it returns to accepting commands.

Result values come from stub inputs. These are status bytes, a present-cylinder byte, a version byte and four ID fields, so a test environment can steer what the host reads back. Two status outputs tell the host when it may move a byte and in which direction. The ready flag drops for a programmable number of cycles after every accepted transfer, so host software has to poll for real. Media timing, motors, DMA and actual disk activity are not part of this block.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After reset, `stat_ready` is 1, `stat_dir` is 0 (host-to-controller), `stat_busy` is 0 and `host_rdata` is 0.
- R2: The command type comes from bits 4:0 of the first byte, and bits 7:5 are ignored. The codes are 0x06 read data and 0x05 write data, both 9 bytes long. Code 0x0D is format, 6 bytes. Code 0x13 is configure, 4 bytes. Codes 0x0F seek and 0x03 specify take 3 bytes each. Codes 0x07 recalibrate, 0x04 sense drive status and 0x0A read ID take 2 bytes each. Codes 0x08 sense interrupt and 0x10 version are 1 byte. Every other code is invalid and 1 byte long. While a command is only partly received, `stat_busy` is 1 and `stat_dir` is 0.
- R3: Format, configure, seek, specify and recalibrate have no result phase. After their last byte, `stat_busy` and `stat_dir` are both 0.
- R4: Read data, write data and read ID return 7 bytes in this order: status 0, status 1, status 2, cylinder, head, sector, size code. The last four come from `stub_id` bits [31:24], [23:16], [15:8] and [7:0]. In the returned status 0, bits 7:3 come from `stub_st0`, bit 2 is the head bit and bits 1:0 are the unit bits of the second command byte.
- R5: Sense interrupt returns 2 bytes: `stub_st0` unchanged, then `stub_pcn`. Version returns 1 byte, `stub_ver`.
- R6: Sense drive status returns 1 byte. Bits 7:3 come from `stub_st3`, bit 2 is the head bit and bits 1:0 are the unit bits of its second command byte.
- R7: An invalid opcode returns exactly one byte, 0x80, and then goes back to idle.
- R8: `stat_dir` rises on the edge that accepts a result-bearing command's last byte. It falls on the edge that accepts the last result byte, and `stat_busy` falls with it.
- R9: After each accepted transfer, `stat_ready` is 0 for exactly HOLD_CYC cycles and then returns to 1.
- R10: The following are ignored: a write strobe while not ready or while `stat_dir` is 1, and a read strobe while not ready or while `stat_dir` is 0. `host_rdata` is 0 whenever `stat_dir` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the data port |
| host_rd | input | 1 | Host read strobe for the data port |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Result byte presented to the host |
| stat_ready | output | 1 | Data port may be accessed |
| stat_dir | output | 1 | 1 = controller-to-host (result phase) |
| stat_busy | output | 1 | A command is in progress |
| stub_st0 | input | 8 | Status 0 source |
| stub_st1 | input | 8 | Status 1 source |
| stub_st2 | input | 8 | Status 2 source |
| stub_st3 | input | 8 | Status 3 source |
| stub_pcn | input | 8 | Present cylinder source |
| stub_id | input | 32 | Cylinder, head, sector, size code |
| stub_ver | input | 8 | Version byte source |

## Verification
In any one cycle the host can raise its write strobe and its read strobe together. It can also strobe during the last cycle of a ready hold-off. In both cases the transfer logic has to pick at most one winner. The bench provokes this in two ways. It asserts both strobes at once while a command is being received. It also writes straight after a write, while ready is still low. The verdict comes from the sequencing that follows: the byte count, the direction bit and the returned data must match what exactly the accepted transfers would produce.

// File: rtl/fdc_seq_pkg.sv
// Package: shared command kinds, field widths and fixed codes for the
// floppy command sequencer. Assumes opcodes are identified by 5 bits.
package fdc_seq_pkg;
    localparam int CLEN_W   = 4;   // holds command lengths up to 9
    localparam int RIDX_W   = 3;   // holds result lengths up to 7
    localparam int OPC_W    = 5;
    localparam logic [7:0] BAD_CMD_BYTE = 8'h80;

    typedef enum logic [3:0] {
        K_READ, K_WRITE, K_FORMAT, K_READID, K_RECAL, K_SEEK,
        K_SNSINT, K_SNSDRV, K_SPECIFY, K_CONFIG, K_VERSION, K_INVALID
    } cmd_kind_e;
endpackage

// File: rtl/fdc_op_decode.sv
// Module: maps the low opcode bits to a command kind, a command length
// and a result length. Purely combinational; assumes high bits are flags.
module fdc_op_decode
    import fdc_seq_pkg::*;
(
    input  logic [OPC_W-1:0]  opc,
    output cmd_kind_e         kind,
    output logic [CLEN_W-1:0] clen,
    output logic [RIDX_W-1:0] rlen
);
    // Decode table of opcode to kind and lengths.
    always_comb begin
        case (opc)
            5'h06:   begin kind = K_READ;    clen = 4'd9; rlen = 3'd7; end
            5'h05:   begin kind = K_WRITE;   clen = 4'd9; rlen = 3'd7; end
            5'h0D:   begin kind = K_FORMAT;  clen = 4'd6; rlen = 3'd0; end
            5'h0A:   begin kind = K_READID;  clen = 4'd2; rlen = 3'd7; end
            5'h07:   begin kind = K_RECAL;   clen = 4'd2; rlen = 3'd0; end
            5'h0F:   begin kind = K_SEEK;    clen = 4'd3; rlen = 3'd0; end
            5'h08:   begin kind = K_SNSINT;  clen = 4'd1; rlen = 3'd2; end
            5'h04:   begin kind = K_SNSDRV;  clen = 4'd2; rlen = 3'd1; end
            5'h03:   begin kind = K_SPECIFY; clen = 4'd3; rlen = 3'd0; end
            5'h13:   begin kind = K_CONFIG;  clen = 4'd4; rlen = 3'd0; end
            5'h10:   begin kind = K_VERSION; clen = 4'd1; rlen = 3'd1; end
            default: begin kind = K_INVALID; clen = 4'd1; rlen = 3'd1; end
        endcase
    end
endmodule

// File: rtl/fdc_ready_timer.sv
// Module: holds the ready flag low for HOLD_CYC cycles after each
// accepted access. Assumes accesses are only accepted while ready.
module fdc_ready_timer #(
    parameter int HOLD_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    output logic ready
);
    localparam int CW = (HOLD_CYC < 1) ? 1 : $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

    logic [CW-1:0] cnt_q;

    // Load the hold-off on access, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (access)      cnt_q <= LOAD;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign ready = (cnt_q == '0);
endmodule

// File: rtl/fdc_result_mux.sv
// Module: selects the result byte for the current command kind and index.
// Assumes idx stays below the result length of the kind.
module fdc_result_mux
    import fdc_seq_pkg::*;
(
    input  cmd_kind_e         kind,
    input  logic [RIDX_W-1:0] idx,
    input  logic              dir,
    input  logic              head,
    input  logic [1:0]        unit,
    input  logic [7:0]        st0,
    input  logic [7:0]        st1,
    input  logic [7:0]        st2,
    input  logic [7:0]        st3,
    input  logic [7:0]        pcn,
    input  logic [31:0]       id,
    input  logic [7:0]        ver,
    output logic [7:0]        rdata
);
    logic [7:0] st0_tag, st3_tag;
    assign st0_tag = {st0[7:3], head, unit};
    assign st3_tag = {st3[7:3], head, unit};

    // Pick the byte; zero outside the result phase.
    always_comb begin
        rdata = 8'h00;
        if (dir) begin
            case (kind)
                K_READ, K_WRITE, K_READID: begin
                    case (idx)
                        3'd0:    rdata = st0_tag;
                        3'd1:    rdata = st1;
                        3'd2:    rdata = st2;
                        3'd3:    rdata = id[31:24];
                        3'd4:    rdata = id[23:16];
                        3'd5:    rdata = id[15:8];
                        default: rdata = id[7:0];
                    endcase
                end
                K_SNSINT:  rdata = (idx == 3'd0) ? st0 : pcn;
                K_SNSDRV:  rdata = st3_tag;
                K_VERSION: rdata = ver;
                default:   rdata = BAD_CMD_BYTE;
            endcase
        end
    end
endmodule

// File: rtl/fdc_cmd_seq.sv
// Module: top of the command-phase sequencer. Counts command bytes per
// opcode, then presents result bytes and returns to idle. Assumes one
// access per strobe cycle; strobes that do not match the state are dropped.
module fdc_cmd_seq
    import fdc_seq_pkg::*;
#(
    parameter int HOLD_CYC = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        stat_ready,
    output logic        stat_dir,
    output logic        stat_busy,
    input  logic [7:0]  stub_st0,
    input  logic [7:0]  stub_st1,
    input  logic [7:0]  stub_st2,
    input  logic [7:0]  stub_st3,
    input  logic [7:0]  stub_pcn,
    input  logic [31:0] stub_id,
    input  logic [7:0]  stub_ver
);
    cmd_kind_e          dec_kind, kind_q;
    logic [CLEN_W-1:0]  dec_clen, clen_q, cur_clen, cnt_q;
    logic [RIDX_W-1:0]  dec_rlen, rlen_q, cur_rlen, ridx_q;
    logic               dir_q, head_q, wr_acc, rd_acc;
    logic [1:0]         unit_q;

    fdc_op_decode u_dec (
        .opc  (host_wdata[OPC_W-1:0]),
        .kind (dec_kind),
        .clen (dec_clen),
        .rlen (dec_rlen)
    );

    fdc_ready_timer #(.HOLD_CYC(HOLD_CYC)) u_rdy (
        .clk    (clk),
        .rst_n  (rst_n),
        .access (wr_acc | rd_acc),
        .ready  (stat_ready)
    );

    assign wr_acc   = host_wr && stat_ready && !dir_q;
    assign rd_acc   = host_rd && stat_ready &&  dir_q;
    assign cur_clen = (cnt_q == '0) ? dec_clen : clen_q;
    assign cur_rlen = (cnt_q == '0) ? dec_rlen : rlen_q;

    // Command/result sequencing state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= K_INVALID;
            clen_q <= '0;
            rlen_q <= '0;
            cnt_q  <= '0;
            ridx_q <= '0;
            dir_q  <= 1'b0;
            head_q <= 1'b0;
            unit_q <= 2'd0;
        end else if (wr_acc) begin
            if (cnt_q == '0) begin
                kind_q <= dec_kind;
                clen_q <= dec_clen;
                rlen_q <= dec_rlen;
            end
            if (cnt_q == CLEN_W'(1)) begin
                head_q <= host_wdata[2];
                unit_q <= host_wdata[1:0];
            end
            if (cnt_q + 1'b1 == cur_clen) begin
                cnt_q  <= '0;
                ridx_q <= '0;
                dir_q  <= (cur_rlen != '0);
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (rd_acc) begin
            if (ridx_q + 1'b1 == rlen_q) begin
                ridx_q <= '0;
                dir_q  <= 1'b0;
            end else begin
                ridx_q <= ridx_q + 1'b1;
            end
        end
    end

    fdc_result_mux u_mux (
        .kind  (kind_q),
        .idx   (ridx_q),
        .dir   (dir_q),
        .head  (head_q),
        .unit  (unit_q),
        .st0   (stub_st0),
        .st1   (stub_st1),
        .st2   (stub_st2),
        .st3   (stub_st3),
        .pcn   (stub_pcn),
        .id    (stub_id),
        .ver   (stub_ver),
        .rdata (host_rdata)
    );

    assign stat_dir  = dir_q;
    assign stat_busy = dir_q || (cnt_q != '0);
endmodule

// File: rtl/fdc_cmd_seq_chk.sv
// Module: property checker for fdc_cmd_seq, attached with bind.
// Assumes it observes only the top-level ports.
module fdc_cmd_seq_chk #(
    parameter int HOLD_CYC = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic       host_rd,
    input logic [7:0] host_rdata,
    input logic       stat_ready,
    input logic       stat_dir,
    input logic       stat_busy
);
    // Result phase implies a command in progress (R8).
    p_dir_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_dir |-> stat_busy);

    // Direction turns only on an accepted write (R2).
    p_dir_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_dir) |-> $past(host_wr && stat_ready));

    // Direction returns only on an accepted read (R8).
    p_dir_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_dir) |-> $past(host_rd && stat_ready));

    // An accepted transfer drops ready on the next cycle (R9).
    p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((HOLD_CYC > 0) && stat_ready &&
         ((host_wr && !stat_dir) || (host_rd && stat_dir))) |=> !stat_ready);

    // Ready falls only after a strobe (R10).
    p_ready_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_ready) |-> $past(host_wr || host_rd));

    // No data is driven outside the result phase (R10).
    p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_dir |-> (host_rdata == 8'h00));
endmodule

bind fdc_cmd_seq fdc_cmd_seq_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .stat_ready (stat_ready),
    .stat_dir   (stat_dir),
    .stat_busy  (stat_busy)
);

// File: tb/fdc_cmd_seq_tb_top.sv
// Directed bench for fdc_cmd_seq: one task per scenario.
module fdc_cmd_seq_tb_top;
    localparam int HOLD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        stat_ready, stat_dir, stat_busy;
    logic [7:0]  stub_st0 = 8'hC5, stub_st1 = 8'h11, stub_st2 = 8'h22;
    logic [7:0]  stub_st3 = 8'h38, stub_pcn = 8'h2A, stub_ver = 8'h90;
    logic [31:0] stub_id  = 32'h2A01_0902;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    fdc_cmd_seq #(.HOLD_CYC(HOLD)) dut_i (.*);

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        while (!(stat_ready && !stat_dir)) @(negedge clk);
        host_wdata = b; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic fetch(output logic [7:0] v);
        while (!(stat_ready && stat_dir)) @(negedge clk);
        v = host_rdata; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    // Generic command: nc bytes out, nr bytes back, every step checked.
    task automatic run_cmd(input logic [7:0] b [9], input int nc,
                           input logic [7:0] e [7], input int nr, input string tag);
        logic [7:0] v;
        for (int i = 0; i < nc; i++) begin
            send(b[i]);
            if (i < nc - 1) chk({stat_busy, stat_dir}, 2'b10, {tag, " mid-command"});
        end
        if (nr == 0) chk({stat_busy, stat_dir}, 2'b00, {tag, " no result phase"});
        else         chk({stat_busy, stat_dir}, 2'b11, {tag, " R8 dir up"});
        for (int j = 0; j < nr; j++) begin
            fetch(v);
            chk(v, e[j], $sformatf("%s result byte %0d", tag, j));
        end
        chk({stat_busy, stat_dir}, 2'b00, {tag, " R8 back to idle"});
    endtask

    task automatic t_reset;
        chk({stat_ready, stat_dir, stat_busy}, 3'b100, "R1 status after reset");
        chk(host_rdata, 8'h00, "R1 rdata after reset");
    endtask

    task automatic t_rw;
        // Read with flag bits set; head 1, unit 2 -> status 0 = 0xC6.
        run_cmd('{8'hE6, 8'h06, 8'h2A, 8'h01, 8'h09, 8'h02, 8'h12, 8'h1B, 8'hFF}, 9,
                '{8'hC6, 8'h11, 8'h22, 8'h2A, 8'h01, 8'h09, 8'h02}, 7, "R2 R4 read");
        // Write; head 0, unit 1 -> status 0 = 0xC1.
        run_cmd('{8'h45, 8'h01, 8'h03, 8'h00, 8'h01, 8'h02, 8'h12, 8'h1B, 8'hFF}, 9,
                '{8'hC1, 8'h11, 8'h22, 8'h2A, 8'h01, 8'h09, 8'h02}, 7, "R2 R4 write");
    endtask

    task automatic t_readid;
        run_cmd('{8'h4A, 8'h07, 0, 0, 0, 0, 0, 0, 0}, 2,
                '{8'hC7, 8'h11, 8'h22, 8'h2A, 8'h01, 8'h09, 8'h02}, 7, "R4 read ID");
    endtask

    task automatic t_nores;
        logic [7:0] z [7] = '{default: 8'h00};
        run_cmd('{8'h4D, 8'h00, 8'h02, 8'h12, 8'h54, 8'hE5, 0, 0, 0}, 6, z, 0, "R3 format");
        run_cmd('{8'h13, 8'h00, 8'h57, 8'h00, 0, 0, 0, 0, 0}, 4, z, 0, "R3 configure");
        run_cmd('{8'h0F, 8'h01, 8'h20, 0, 0, 0, 0, 0, 0}, 3, z, 0, "R3 seek");
        run_cmd('{8'h03, 8'hDF, 8'h02, 0, 0, 0, 0, 0, 0}, 3, z, 0, "R3 specify");
        run_cmd('{8'h07, 8'h00, 0, 0, 0, 0, 0, 0, 0}, 2, z, 0, "R3 recalibrate");
    endtask

    task automatic t_short_results;
        run_cmd('{8'h08, 0, 0, 0, 0, 0, 0, 0, 0}, 1,
                '{8'hC5, 8'h2A, 0, 0, 0, 0, 0}, 2, "R5 sense interrupt");
        run_cmd('{8'h10, 0, 0, 0, 0, 0, 0, 0, 0}, 1,
                '{8'h90, 0, 0, 0, 0, 0, 0}, 1, "R5 version");
        // head 0, unit 3 -> 0x3B
        run_cmd('{8'h04, 8'h03, 0, 0, 0, 0, 0, 0, 0}, 2,
                '{8'h3B, 0, 0, 0, 0, 0, 0}, 1, "R6 sense drive");
        run_cmd('{8'h1F, 0, 0, 0, 0, 0, 0, 0, 0}, 1,
                '{8'h80, 0, 0, 0, 0, 0, 0}, 1, "R7 invalid 0x1F");
        run_cmd('{8'h00, 0, 0, 0, 0, 0, 0, 0, 0}, 1,
                '{8'h80, 0, 0, 0, 0, 0, 0}, 1, "R7 invalid 0x00");
    endtask

    task automatic t_hold;
        int n = 0;
        send(8'h03);
        while (!stat_ready && n < 50) begin n++; @(negedge clk); end
        chk(n, HOLD, "R9 ready low cycles");
        send(8'hDF); send(8'h02);
        chk(stat_busy, 1'b0, "R9 specify finished");
    endtask

    task automatic t_ignored;
        logic [7:0] v;
        // Write during hold-off must not count as the second byte.
        send(8'h07);
        host_wdata = 8'h00; host_wr = 1'b1; @(negedge clk); host_wr = 1'b0;
        while (!stat_ready) @(negedge clk);
        chk({stat_busy, stat_dir}, 2'b10, "R10 write while not ready ignored");
        send(8'h00);
        chk(stat_busy, 1'b0, "R10 recalibrate done after real byte");
        // Read strobe in command phase has no effect.
        send(8'h0F);
        while (!stat_ready) @(negedge clk);
        host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
        chk({stat_busy, stat_dir, host_rdata}, {2'b10, 8'h00}, "R10 read in command phase ignored");
        chk(stat_ready, 1'b1, "R10 ignored read keeps ready");
        send(8'h00); send(8'h05);
        chk(stat_busy, 1'b0, "R10 seek done");
        // Write strobe in result phase has no effect.
        send(8'h08);
        while (!stat_ready) @(negedge clk);
        host_wdata = 8'h10; host_wr = 1'b1; @(negedge clk); host_wr = 1'b0;
        chk({stat_dir, host_rdata}, {1'b1, 8'hC5}, "R10 write in result phase ignored");
        fetch(v); chk(v, 8'hC5, "R10 sense int byte 0");
        fetch(v); chk(v, 8'h2A, "R10 sense int byte 1");
        chk(stat_dir, 1'b0, "R10 sense int finished");
    endtask

    task automatic t_both;
        logic [7:0] v;
        while (!(stat_ready && !stat_dir)) @(negedge clk);
        host_wdata = 8'h10; host_wr = 1'b1; host_rd = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
        chk({stat_dir, stat_ready}, 2'b10, "R10 simultaneous strobes: write taken");
        fetch(v); chk(v, 8'h90, "R5 version after simultaneous strobes");
        chk(stat_busy, 1'b0, "R8 idle after version");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rw();
        t_readid();
        t_nores();
        t_short_results();
        t_hold();
        t_ignored();
        t_both();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule